// File: doc/BRIEF.md
# Register-Driven NAND Flash Bus Controller

This block lets a processor reach an 8-bit NAND flash device through four byte-wide registers. A mode register sets the bus phase: command (CLE high), address (ALE high), payload data (both low), or ECC readout. In every phase except ECC readout, the processor reaches the flash through a single data register. Each access to that register launches exactly one external write-enable or read-enable strobe cycle. The processor's request stays stalled until that strobe cycle has finished.

A strobe-width register sets how many clocks the enable line stays low. An interrupt control register gates an interrupt that is raised when the flash ready/busy line goes high. The ECC arithmetic sits in a separate block. This controller only sends that block a clear pulse and a byte-read pulse, and passes the ECC byte back to the processor in ECC readout mode.

A typical page program runs as follows:
- Write mode 0x7C to clear the ECC.
- Write mode 0x9D, then send command byte 0x80 through the data register.
- Write mode 0x9E, then send the address bytes: A[7:0], A[16:9], A[24:17], and optionally A[25].
- Write mode 0xBC, then stream the 512 payload bytes.
- Write mode 0xDC, then read the six ECC bytes.

Top module: `nand_bus_ctrl`

## Requirements
- R1: After reset, the outputs are CLE=0, ALE=0, we_n=1, re_n=1 and irq=0. The mode register (address 1) reads 0x00, and the width register (address 2) reads 0.
- R2: Writing 0x9D to address 1 drives CLE=1 and ALE=0. Each later write to the data register (address 0) drives the byte on fl_dout with fl_doe high, and pulses we_n low while CLE is high.
- R3: Writing 0x9E to address 1 drives ALE=1 and CLE=0. Data-register writes then go out as address bytes under the same strobe.
- R4: Writing 0xBC to address 1 drives CLE=0 and ALE=0. A data-register read pulses re_n low and returns the fl_din value sampled in the last low cycle. we_n stays high during the read.
- R5: The low time of a strobe is max(W,1) clocks, where W is the value written to the width register (address 2). The low time is preceded by one setup clock and followed by one recovery clock. req_ready is high only in the recovery clock, so an accepted data access completes W'+2 clocks after it is presented, where W' = max(W,1).
- R6: Writing 0x7C to address 1 gives exactly one ecc_clr pulse, one clock long, and selects the data phase (CLE=0, ALE=0).
- R7: Writing 0xDC to address 1 selects ECC readout. In this mode, a data-register read returns ecc_byte in the same clock, with one ecc_rd pulse and no strobe. A data-register write completes in the same clock and issues no strobe.
- R8: Writing any other value to address 1 is ignored. The mode readback, CLE and ALE all keep their previous values.
- R9: An access to addresses 1, 2 or 3 completes in the clock it is presented (req_ready high in that clock) and issues no strobe.
- R10: Address 3 is the interrupt control register:
  - Bit 0 is the interrupt enable.
  - Writing a 1 to bit 7 clears the pending interrupt.
  - Reading returns {pending, synchronized ready/busy, 5'b0, enable}.
  - A rising edge of fl_rb while enabled sets pending, and irq follows pending.
  - A rising edge while disabled sets nothing.
- R11: we_n and re_n are never low together, and CLE and ALE are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request valid, held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register select: 0 data, 1 mode, 2 width, 3 interrupt control |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request completes on this clock |
| rsp_rdata | output | 8 | Read data, valid while req_ready is high |
| fl_cle | output | 1 | Flash command latch enable |
| fl_ale | output | 1 | Flash address latch enable |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_re_n | output | 1 | Flash read enable, active low |
| fl_dout | output | 8 | Byte driven to the flash |
| fl_doe | output | 1 | Output enable for fl_dout |
| fl_din | input | 8 | Byte from the flash |
| fl_rb | input | 1 | Flash ready (1) / busy (0) |
| ecc_clr | output | 1 | Clear pulse to the ECC block |
| ecc_rd | output | 1 | ECC byte taken this clock |
| ecc_byte | input | 8 | Current ECC byte from the ECC block |
| irq | output | 1 | Ready interrupt |

## Verification
The bench counts strobe-low clocks at several widths, including zero. A counter that is off by one, or one that does not clamp zero to a single clock, shows up as the wrong low count or the wrong completion latency. ECC readout mode is probed with both a read and a write. A design that still strobes the flash in that mode, or that returns flash data instead of the ECC byte, is caught at the ports. An unrecognized mode code is written mid-sequence, which catches a decoder that drops CLE or loads the code anyway. The interrupt is driven with the enable both on and off, and cleared with a bit-7 write, which exposes set and clear logic that ignores the enable or the clear bit.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA, PH_ECC} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_LOW, ST_REC} strobe_e;

  localparam logic [1:0] A_DATA  = 2'd0;
  localparam logic [1:0] A_MODE  = 2'd1;
  localparam logic [1:0] A_WIDTH = 2'd2;
  localparam logic [1:0] A_IRQ   = 2'd3;

  localparam logic [7:0] M_CMD    = 8'h9D;
  localparam logic [7:0] M_ADDR   = 8'h9E;
  localparam logic [7:0] M_DATA   = 8'hBC;
  localparam logic [7:0] M_ECCCLR = 8'h7C;
  localparam logic [7:0] M_ECCRD  = 8'hDC;
endpackage

// File: rtl/nbc_regs.sv
module nbc_regs
  import nbc_pkg::*;
#(
  parameter int WIDTH_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [7:0]         wdata,
  input  logic               rb_sync,
  input  logic               irq_pend,
  output phase_e             phase,
  output logic [WIDTH_W-1:0] width_val,
  output logic               irq_en,
  output logic               irq_clr,
  output logic               ecc_clr,
  output logic [7:0]         rdata
);
  phase_e             phase_q, phase_d, phase_sel;
  logic [7:0]         mode_q, mode_d;
  logic [WIDTH_W-1:0] width_q, width_d;
  logic               en_q, en_d;
  logic               eclr_q, eclr_d;
  logic               mode_wr, known;

  // mode decode and register next state
  always_comb begin
    phase_d   = phase_q;
    mode_d    = mode_q;
    width_d   = width_q;
    en_d      = en_q;
    mode_wr   = wr_en && (addr == A_MODE);
    known     = 1'b1;
    phase_sel = phase_q;
    case (wdata)
      M_CMD:    phase_sel = PH_CMD;
      M_ADDR:   phase_sel = PH_ADDR;
      M_DATA:   phase_sel = PH_DATA;
      M_ECCCLR: phase_sel = PH_DATA;
      M_ECCRD:  phase_sel = PH_ECC;
      default:  known     = 1'b0;
    endcase
    if (mode_wr && known) begin
      mode_d  = wdata;
      phase_d = phase_sel;
    end
    eclr_d = mode_wr && (wdata == M_ECCCLR);
    if (wr_en && (addr == A_WIDTH)) width_d = wdata[WIDTH_W-1:0];
    if (wr_en && (addr == A_IRQ))   en_d    = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_DATA;
      mode_q  <= 8'h00;
      width_q <= '0;
      en_q    <= 1'b0;
      eclr_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      mode_q  <= mode_d;
      width_q <= width_d;
      en_q    <= en_d;
      eclr_q  <= eclr_d;
    end
  end

  always_comb begin
    case (addr)
      A_MODE:  rdata = mode_q;
      A_WIDTH: rdata = 8'(width_q);
      A_IRQ:   rdata = {irq_pend, rb_sync, 5'b00000, en_q};
      default: rdata = 8'h00;
    endcase
  end

  assign phase     = phase_q;
  assign width_val = width_q;
  assign irq_en    = en_q;
  assign irq_clr   = wr_en && (addr == A_IRQ) && wdata[7];
  assign ecc_clr   = eclr_q;

  // R6: a clear pulse only follows a write of the ECC-clear code
  p_ecc_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_clr |-> (mode_q == M_ECCCLR) && (phase_q == PH_DATA));
  // R8: unknown mode codes leave mode and phase untouched
  p_bad_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !known) |=> ($stable(mode_q) && $stable(phase_q)));
endmodule

// File: rtl/nbc_rb_irq.sv
module nbc_rb_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_in,
  input  logic en,
  input  logic clr,
  output logic rb_sync,
  output logic pend
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pend_q, pend_d;
  logic                   set;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= rb_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rb_in};
      end
    end
  endgenerate

  assign rb_sync = sync_q[SYNC_STAGES-1];
  assign set     = rb_sync && !prev_q && en;

  always_comb begin
    pend_d = pend_q;
    if (clr) pend_d = 1'b0;
    if (set) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= rb_sync;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R10: pending rises only while enabled
  p_irq_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(en));
  // R10: a clear with no new edge drops pending
  p_irq_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !pend_q);
endmodule

// File: rtl/nbc_strobe.sv
module nbc_strobe
  import nbc_pkg::*;
#(
  parameter int WIDTH_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_rd,
  input  logic [7:0]         start_data,
  input  logic [WIDTH_W-1:0] width,
  input  logic [7:0]         din,
  output logic               we_n,
  output logic               re_n,
  output logic               doe,
  output logic [7:0]         dout,
  output logic [7:0]         rdata,
  output logic               idle,
  output logic               done
);
  localparam logic [WIDTH_W-1:0] ONE = WIDTH_W'(1);

  strobe_e            state_q, state_d;
  logic [WIDTH_W-1:0] cnt_q, cnt_d;
  logic               rd_q, rd_d;
  logic [7:0]         dout_q, dout_d;
  logic [7:0]         rdata_q, rdata_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rd_d    = rd_q;
    dout_d  = dout_q;
    rdata_d = rdata_q;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_SETUP;
        rd_d    = start_rd;
        dout_d  = start_data;
      end
      ST_SETUP: begin
        state_d = ST_LOW;
        cnt_d   = (width == '0) ? ONE : width;
      end
      ST_LOW: begin
        if (cnt_q == ONE) begin
          state_d = ST_REC;
          if (rd_q) rdata_d = din;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      ST_REC:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      dout_q  <= 8'h00;
      rdata_q <= 8'h00;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rd_q    <= rd_d;
      dout_q  <= dout_d;
      rdata_q <= rdata_d;
    end
  end

  assign we_n  = !((state_q == ST_LOW) && !rd_q);
  assign re_n  = !((state_q == ST_LOW) && rd_q);
  assign doe   = (state_q != ST_IDLE) && !rd_q;
  assign dout  = dout_q;
  assign rdata = rdata_q;
  assign idle  = (state_q == ST_IDLE);
  assign done  = (state_q == ST_REC);

  // R11: the two enables are never low together
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  // R5: every low pulse is entered from the setup clock
  p_setup_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n && re_n) |-> $past(state_q == ST_SETUP));
  // R5: completion is a single clock
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: write data is driven throughout the low pulse
  p_doe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> doe);
endmodule

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl
  import nbc_pkg::*;
#(
  parameter int WIDTH_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [1:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       req_ready,
  output logic [7:0] rsp_rdata,
  output logic       fl_cle,
  output logic       fl_ale,
  output logic       fl_we_n,
  output logic       fl_re_n,
  output logic [7:0] fl_dout,
  output logic       fl_doe,
  input  logic [7:0] fl_din,
  input  logic       fl_rb,
  output logic       ecc_clr,
  output logic       ecc_rd,
  input  logic [7:0] ecc_byte,
  output logic       irq
);
  logic [1:0]         rst_pipe;
  logic               rst_int;
  phase_e             phase;
  logic [WIDTH_W-1:0] width_val;
  logic               irq_en, irq_clr, rb_sync, pend;
  logic               st_idle, st_done;
  logic [7:0]         st_rdata, reg_rdata;
  logic               needs_strobe, ext_go, local_ack, reg_wr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  assign needs_strobe = (req_addr == A_DATA) && (phase != PH_ECC);
  assign ext_go       = req_valid && st_idle && needs_strobe;
  assign local_ack    = req_valid && st_idle && !needs_strobe;
  assign reg_wr       = local_ack && req_write && (req_addr != A_DATA);
  assign ecc_rd       = local_ack && !req_write && (req_addr == A_DATA);
  assign req_ready    = local_ack || st_done;
  assign rsp_rdata    = st_done ? st_rdata
                      : ((req_addr == A_DATA) ? ecc_byte : reg_rdata);
  assign fl_cle       = (phase == PH_CMD);
  assign fl_ale       = (phase == PH_ADDR);
  assign irq          = pend;

  nbc_regs #(.WIDTH_W(WIDTH_W)) u_regs (
    .clk(clk), .rst_n(rst_int), .wr_en(reg_wr), .addr(req_addr),
    .wdata(req_wdata), .rb_sync(rb_sync), .irq_pend(pend), .phase(phase),
    .width_val(width_val), .irq_en(irq_en), .irq_clr(irq_clr),
    .ecc_clr(ecc_clr), .rdata(reg_rdata)
  );

  nbc_strobe #(.WIDTH_W(WIDTH_W)) u_strobe (
    .clk(clk), .rst_n(rst_int), .start(ext_go), .start_rd(!req_write),
    .start_data(req_wdata), .width(width_val), .din(fl_din),
    .we_n(fl_we_n), .re_n(fl_re_n), .doe(fl_doe), .dout(fl_dout),
    .rdata(st_rdata), .idle(st_idle), .done(st_done)
  );

  nbc_rb_irq #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk(clk), .rst_n(rst_int), .rb_in(fl_rb), .en(irq_en), .clr(irq_clr),
    .rb_sync(rb_sync), .pend(pend)
  );

  // R11: latch enables are exclusive
  p_cle_ale_r11: assert property (@(posedge clk) disable iff (!rst_int)
    !(fl_cle && fl_ale));
  // R9: a same-clock completion never coincides with a strobe
  p_local_nostrobe_r9: assert property (@(posedge clk) disable iff (!rst_int)
    local_ack |-> (fl_we_n && fl_re_n));
  // R7: ECC readout phase keeps the flash quiet
  p_ecc_quiet_r7: assert property (@(posedge clk) disable iff (!rst_int)
    (phase == PH_ECC) |-> (fl_we_n && fl_re_n));
endmodule

// File: tb/test_nand_bus_ctrl.sv
`timescale 1ns/1ps
module test_nand_bus_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_addr = 2'd0;
  logic [7:0] req_wdata = 8'h00;
  logic       req_ready;
  logic [7:0] rsp_rdata;
  logic       fl_cle, fl_ale, fl_we_n, fl_re_n, fl_doe;
  logic [7:0] fl_dout;
  logic [7:0] fl_din = 8'h00;
  logic       fl_rb = 1'b1;
  logic       ecc_clr, ecc_rd, irq;
  logic [7:0] ecc_byte = 8'h00;

  int  n_tests = 0, n_fail = 0;
  int  n_clr = 0, n_erd = 0, n_excl = 0;
  bit  finished = 0;

  // access results
  logic [7:0] a_rd, a_dout;
  int         a_cyc, a_we, a_re;
  bit         a_cle, a_ale;

  always #5 clk = ~clk;

  nand_bus_ctrl i_nand_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata), .fl_cle(fl_cle), .fl_ale(fl_ale),
    .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_dout(fl_dout),
    .fl_doe(fl_doe), .fl_din(fl_din), .fl_rb(fl_rb), .ecc_clr(ecc_clr),
    .ecc_rd(ecc_rd), .ecc_byte(ecc_byte), .irq(irq)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (ecc_clr) n_clr++;
      if (ecc_rd)  n_erd++;
      if ((!fl_we_n && !fl_re_n) || (fl_cle && fl_ale)) n_excl++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    a_cyc = 0; a_we = 0; a_re = 0; a_cle = 0; a_ale = 0; a_dout = 8'h00;
    forever begin
      @(negedge clk);
      if (!fl_we_n) begin
        a_we++; a_cle = fl_cle; a_ale = fl_ale; a_dout = fl_dout;
      end
      if (!fl_re_n) a_re++;
      if (req_ready) begin a_rd = rsp_rdata; break; end
      a_cyc++;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cle", fl_cle, 0);
    chk("R1 ale", fl_ale, 0);
    chk("R1 we_n", fl_we_n, 1);
    chk("R1 re_n", fl_re_n, 1);
    chk("R1 irq", irq, 0);
    access(0, 2'd1, 8'h00);
    chk("R1 mode readback", a_rd, 8'h00);
    chk("R9 same-clock completion", a_cyc, 0);
    access(0, 2'd2, 8'h00);
    chk("R1 width readback", a_rd, 0);
  endtask

  task automatic t_command();
    access(1, 2'd1, 8'h9D);
    chk("R9 mode write no strobe", a_we, 0);
    chk("R2 cle", fl_cle, 1);
    chk("R2 ale", fl_ale, 0);
    access(1, 2'd0, 8'h80);
    chk("R5 width0 low clocks", a_we, 1);
    chk("R5 width0 latency", a_cyc, 3);
    chk("R2 cle during strobe", a_cle, 1);
    chk("R2 command byte", a_dout, 8'h80);
  endtask

  task automatic t_address();
    logic [7:0] bytes [3];
    bytes[0] = 8'h12; bytes[1] = 8'h34; bytes[2] = 8'h56;
    access(1, 2'd2, 8'h03);
    access(0, 2'd2, 8'h00);
    chk("R9 width readback", a_rd, 3);
    access(1, 2'd1, 8'h9E);
    chk("R3 ale", fl_ale, 1);
    chk("R3 cle", fl_cle, 0);
    for (int i = 0; i < 3; i++) begin
      access(1, 2'd0, bytes[i]);
      chk("R5 width3 low clocks", a_we, 3);
      chk("R5 width3 latency", a_cyc, 5);
      chk("R3 ale during strobe", a_ale, 1);
      chk("R3 address byte", a_dout, bytes[i]);
    end
  endtask

  task automatic t_data_read();
    access(1, 2'd1, 8'hBC);
    chk("R4 cle", fl_cle, 0);
    chk("R4 ale", fl_ale, 0);
    fl_din = 8'hA5;
    access(0, 2'd0, 8'h00);
    chk("R4 read data", a_rd, 8'hA5);
    chk("R4 re low clocks", a_re, 3);
    chk("R4 no we on read", a_we, 0);
    access(1, 2'd2, 8'h00);
    fl_din = 8'h3C;
    access(0, 2'd0, 8'h00);
    chk("R4 read data width0", a_rd, 8'h3C);
    chk("R5 re width0 low clocks", a_re, 1);
    access(1, 2'd2, 8'h0F);
    access(1, 2'd0, 8'hC3);
    chk("R5 width15 low clocks", a_we, 15);
    chk("R5 width15 latency", a_cyc, 17);
    chk("R4 payload byte", a_dout, 8'hC3);
    access(1, 2'd2, 8'h00);
  endtask

  task automatic t_ecc();
    int c0, e0;
    c0 = n_clr;
    access(1, 2'd1, 8'h9D);
    access(1, 2'd1, 8'h7C);
    @(posedge clk); #1;
    chk("R6 one clear pulse", n_clr - c0, 1);
    chk("R6 data phase cle", fl_cle, 0);
    chk("R6 data phase ale", fl_ale, 0);
    access(1, 2'd1, 8'hDC);
    ecc_byte = 8'h5A;
    e0 = n_erd;
    access(0, 2'd0, 8'h00);
    chk("R7 ecc byte", a_rd, 8'h5A);
    chk("R7 ecc read no strobe", a_re, 0);
    chk("R7 ecc read latency", a_cyc, 0);
    chk("R7 ecc_rd pulse", n_erd - e0, 1);
    access(1, 2'd0, 8'hEE);
    chk("R7 write ignored no strobe", a_we, 0);
    chk("R7 write latency", a_cyc, 0);
    access(0, 2'd1, 8'h00);
    chk("R7 mode readback", a_rd, 8'hDC);
  endtask

  task automatic t_bad_mode();
    access(1, 2'd1, 8'h9D);
    access(1, 2'd1, 8'h55);
    access(0, 2'd1, 8'h00);
    chk("R8 mode unchanged", a_rd, 8'h9D);
    chk("R8 cle held", fl_cle, 1);
    chk("R8 ale held", fl_ale, 0);
    access(1, 2'd1, 8'hBC);
  endtask

  task automatic t_irq();
    fl_rb = 1'b0;
    repeat (6) @(posedge clk);
    access(1, 2'd3, 8'h81);
    fl_rb = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    chk("R10 irq on rising ready", irq, 1);
    access(0, 2'd3, 8'h00);
    chk("R10 status", a_rd, 8'hC1);
    access(1, 2'd3, 8'h81);
    chk("R10 cleared", irq, 0);
    access(1, 2'd3, 8'h00);
    fl_rb = 1'b0;
    repeat (6) @(posedge clk);
    access(0, 2'd3, 8'h00);
    chk("R10 status busy disabled", a_rd, 8'h00);
    fl_rb = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    chk("R10 no irq when disabled", irq, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_command();
    t_address();
    t_data_read();
    t_ecc();
    t_bad_mode();
    t_irq();
    chk("R11 exclusive strobes and latches", n_excl, 0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule